// File: doc/BRIEF.md
# Guarded Configuration and Interrupt Register Block

This block is the register file of a flash memory controller. It holds the settings that the flash interface logic reads continuously: an interface configuration word and a timing word. Both are protected by a key. A stray or runaway write cannot change them unless the key was presented just before. The block also holds an interrupt mask, a sticky interrupt status word that clears when read, a live ready-status word, a chip-enable mode bit and a command word that triggers a soft reset.

Software first writes the key value 0xA25E to the key register and then performs a single write to one guarded register. The key closes again by itself after that write. The controller datapath reports events as single-cycle pulses. Each pulse sets a sticky status flag. The flags, gated by the mask, drive one level-sensitive interrupt line. The bus is a simple word-addressed 32-bit register bus. Read data is returned in the cycle after the read strobe.

Word map: 0 command, 1 key, 2 interface configuration, 3 timing, 4 interrupt mask, 5 interrupt status, 6 live status, 7 chip-enable mode.

Top module: `nfc_cfg_regs`

## Requirements
- R1: A write to word 1 whose low 16 bits equal 0xA25E opens the key, and any other write to word 1 closes it. While the key is open, word 1 reads back 1 in bit 0. The key closes after the first write to word 2 or word 3.
- R2: A write to word 2 or word 3 while the key is closed is dropped and leaves the register and its output unchanged.
- R3: Word 2 holds 4 bits: bit 3 write protect, bit 2 large block, bit 1 long address, bit 0 wide bus. Word 3 holds 26 bits: 25:24 chip-enable-to-access delay, 23:19 busy delay, 18:16 turnaround, 15:12 read high, 11:8 read low, 7:4 write high, 3:0 write low. Both drive `if_cfg` and `tim_cfg` and read back with the upper bits zero. Both reset to zero.
- R4: Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled high, and is zero otherwise. Word 0 reads as zero.
- R5: In word 5, event pulse bit i sets sticky flag i. The bit map is: 5 flash ready, 4 controller ready, 3 decode failure, 2 decode error, 1 ECC ready, 0 write-protect fault. A read of word 5 returns the flags and clears them.
- R6: An event that arrives in the same cycle as a read of word 5 is kept set after that read.
- R7: `irq` is high exactly when some status flag and its mask bit are both set. The mask is the low 6 bits of word 4. `irq` rises in the cycle after the event pulse.
- R8: Word 6 reads `nand_rdy` in bit 0 and `ctrl_rdy` in bit 1, whatever the mask holds.
- R9: Bit 0 of word 7 selects normal chip-enable operation and drives `ce_normal`.
- R10: Writing 0xFF in the low byte of word 0 pulses `soft_rst` high for one cycle, starting the next cycle. The same write returns every register to its reset value and closes the key. Other command values have no effect.
- R11: Writes to word 5 and word 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| evt_pulse | input | 6 | Single-cycle event pulses from the datapath |
| nand_rdy | input | 1 | Live flash ready level |
| ctrl_rdy | input | 1 | Live controller ready level |
| if_cfg | output | 4 | Interface configuration word |
| tim_cfg | output | 26 | Timing word |
| ce_normal | output | 1 | Normal chip-enable mode |
| irq | output | 1 | Level interrupt |
| soft_rst | output | 1 | One-cycle soft reset pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit key of 0xA25E, 6 event lines, a 4-bit configuration word and a 26-bit timing word. With these values every field position is reachable. Writing all ones checks the masking of the upper bits. The 6-bit event vector covers masked and unmasked flags side by side. The bench drives an event pulse and a status read into the same cycle, and it checks the key's single-use window directly on both guarded words.

// File: rtl/nfc_regs_pkg.sv
`timescale 1ns/1ps
package nfc_regs_pkg;
  localparam int unsigned REG_AW = 3;
  typedef logic [REG_AW-1:0] reg_addr_t;

  localparam reg_addr_t A_CMD  = 3'd0;
  localparam reg_addr_t A_KEY  = 3'd1;
  localparam reg_addr_t A_CFG  = 3'd2;
  localparam reg_addr_t A_TIM  = 3'd3;
  localparam reg_addr_t A_MASK = 3'd4;
  localparam reg_addr_t A_STAT = 3'd5;
  localparam reg_addr_t A_LIVE = 3'd6;
  localparam reg_addr_t A_CE   = 3'd7;

  // interrupt level from flags and enables
  function automatic logic any_pending(input logic [31:0] st, input logic [31:0] mk);
    return |(st & mk);
  endfunction

  // one sticky flag: read clear first, then a new event sets it again
  function automatic logic sticky_next(input logic cur, input logic evt, input logic rd_clr);
    return (cur & ~rd_clr) | evt;
  endfunction
endpackage

// File: rtl/nfc_key_lock.sv
`timescale 1ns/1ps
module nfc_key_lock #(
  parameter int unsigned KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY_VAL = 16'hA25E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_data,
  input  logic             guard_wr,
  output logic             open_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)        open_o <= 1'b0;
    else if (clr)      open_o <= 1'b0;
    else if (key_wr)   open_o <= (key_data == KEY_VAL);
    else if (guard_wr) open_o <= 1'b0;
  end
endmodule

// File: rtl/nfc_guard_reg.sv
`timescale 1ns/1ps
module nfc_guard_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (we)  q <= d;
  end
endmodule

// File: rtl/nfc_irq_unit.sv
`timescale 1ns/1ps
module nfc_irq_unit import nfc_regs_pkg::*; #(
  parameter int unsigned EVT_N = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [EVT_N-1:0] evt,
  input  logic             rd_clr,
  input  logic             mask_we,
  input  logic [EVT_N-1:0] mask_d,
  output logic [EVT_N-1:0] mask_q,
  output logic [EVT_N-1:0] stat_q,
  output logic             irq_o
);
  for (genvar i = 0; i < EVT_N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk) begin
      if (!rst_n)   flag_q <= 1'b0;
      else if (clr) flag_q <= 1'b0;
      else          flag_q <= sticky_next(flag_q, evt[i], rd_clr);
    end
    assign stat_q[i] = flag_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (clr)     mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end

  assign irq_o = any_pending(32'(stat_q), 32'(mask_q));
endmodule

// File: rtl/nfc_cfg_regs.sv
`timescale 1ns/1ps
module nfc_cfg_regs import nfc_regs_pkg::*; #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned EVT_N   = 6,
  parameter int unsigned CFG_W   = 4,
  parameter int unsigned TIM_W   = 26,
  parameter int unsigned KEY_W   = 16,
  parameter logic [KEY_W-1:0] KEY_VAL = 16'hA25E,
  parameter int unsigned CMD_W   = 8,
  parameter logic [CMD_W-1:0] RST_CMD = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [EVT_N-1:0]  evt_pulse,
  input  logic              nand_rdy,
  input  logic              ctrl_rdy,
  output logic [CFG_W-1:0]  if_cfg,
  output logic [TIM_W-1:0]  tim_cfg,
  output logic              ce_normal,
  output logic              irq,
  output logic              soft_rst
);
  localparam int unsigned USED_W = TIM_W;

  // named events for the checker
  logic wr_guard_hit, lock_open, sreset_now, stat_rd_clr;
  logic cfg_commit, tim_commit;
  logic [EVT_N-1:0] stat_bits, mask_bits;
  logic [DATA_W-1:0] rd_word;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:USED_W];
  assign wr_guard_hit = bus_wr && (bus_addr == A_CFG || bus_addr == A_TIM);
  assign sreset_now   = bus_wr && (bus_addr == A_CMD) && (bus_wdata[CMD_W-1:0] == RST_CMD);
  assign cfg_commit   = bus_wr && (bus_addr == A_CFG) && lock_open;
  assign tim_commit   = bus_wr && (bus_addr == A_TIM) && lock_open;
  assign stat_rd_clr  = bus_rd && (bus_addr == A_STAT);

  nfc_key_lock #(.KEY_W(KEY_W), .KEY_VAL(KEY_VAL)) u_lock (
    .clk(clk), .rst_n(rst_n), .clr(sreset_now),
    .key_wr(bus_wr && bus_addr == A_KEY), .key_data(bus_wdata[KEY_W-1:0]),
    .guard_wr(wr_guard_hit), .open_o(lock_open)
  );

  nfc_guard_reg #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .clr(sreset_now), .we(cfg_commit),
    .d(bus_wdata[CFG_W-1:0]), .q(if_cfg)
  );

  nfc_guard_reg #(.W(TIM_W)) u_tim (
    .clk(clk), .rst_n(rst_n), .clr(sreset_now), .we(tim_commit),
    .d(bus_wdata[TIM_W-1:0]), .q(tim_cfg)
  );

  nfc_irq_unit #(.EVT_N(EVT_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .clr(sreset_now), .evt(evt_pulse),
    .rd_clr(stat_rd_clr), .mask_we(bus_wr && bus_addr == A_MASK),
    .mask_d(bus_wdata[EVT_N-1:0]), .mask_q(mask_bits), .stat_q(stat_bits),
    .irq_o(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_normal <= 1'b0;
      soft_rst  <= 1'b0;
    end else begin
      soft_rst <= sreset_now;
      if (sreset_now)                    ce_normal <= 1'b0;
      else if (bus_wr && bus_addr == A_CE) ce_normal <= bus_wdata[0];
    end
  end

  always_comb begin
    rd_word = '0;
    unique case (bus_addr)
      A_KEY:   rd_word = DATA_W'(lock_open);
      A_CFG:   rd_word = DATA_W'(if_cfg);
      A_TIM:   rd_word = DATA_W'(tim_cfg);
      A_MASK:  rd_word = DATA_W'(mask_bits);
      A_STAT:  rd_word = DATA_W'(stat_bits);
      A_LIVE:  rd_word = DATA_W'({ctrl_rdy, nand_rdy});
      A_CE:    rd_word = DATA_W'(ce_normal);
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_rd ? rd_word : '0;
  end
endmodule

// File: rtl/nfc_cfg_regs_chk.sv
`timescale 1ns/1ps
module nfc_cfg_regs_chk import nfc_regs_pkg::*; #(
  parameter int unsigned EVT_N = 6,
  parameter int unsigned CFG_W = 4,
  parameter int unsigned TIM_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic [EVT_N-1:0]  evt_pulse,
  input logic [EVT_N-1:0]  stat_bits,
  input logic [EVT_N-1:0]  mask_bits,
  input logic              irq,
  input logic [CFG_W-1:0]  if_cfg,
  input logic [TIM_W-1:0]  tim_cfg,
  input logic              ce_normal,
  input logic              lock_open,
  input logic              wr_guard_hit,
  input logic              stat_rd_clr,
  input logic              sreset_now,
  input logic              soft_rst
);
  AST_KEY_SINGLE_USE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_guard_hit && lock_open) |=> !lock_open); // R1
  AST_LOCKED_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CFG && !lock_open) |=> $stable(if_cfg)); // R2
  AST_LOCKED_TIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_TIM && !lock_open) |=> $stable(tim_cfg)); // R2
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd_clr && !sreset_now) |=> ((stat_bits & $past(stat_bits)) == $past(stat_bits))); // R5
  AST_EVT_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    !sreset_now |=> ((stat_bits & $past(evt_pulse)) == $past(evt_pulse))); // R6
  AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_bits == '0) |-> !irq); // R7
  AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sreset_now |=> (soft_rst && !lock_open && if_cfg == '0 && tim_cfg == '0 && !ce_normal)); // R10
endmodule

bind nfc_cfg_regs nfc_cfg_regs_chk #(.EVT_N(EVT_N), .CFG_W(CFG_W), .TIM_W(TIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .evt_pulse(evt_pulse), .stat_bits(stat_bits), .mask_bits(mask_bits), .irq(irq),
  .if_cfg(if_cfg), .tim_cfg(tim_cfg), .ce_normal(ce_normal), .lock_open(lock_open),
  .wr_guard_hit(wr_guard_hit), .stat_rd_clr(stat_rd_clr), .sreset_now(sreset_now),
  .soft_rst(soft_rst)
);

// File: tb/tb_nfc_cfg_regs.sv
`timescale 1ns/1ps
module tb_nfc_cfg_regs;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  evt_pulse = '0;
  logic        nand_rdy = 1'b0, ctrl_rdy = 1'b0;
  logic [3:0]  if_cfg;
  logic [25:0] tim_cfg;
  logic        ce_normal, irq, soft_rst;

  nfc_cfg_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .nand_rdy(nand_rdy), .ctrl_rdy(ctrl_rdy), .if_cfg(if_cfg), .tim_cfg(tim_cfg),
    .ce_normal(ce_normal), .irq(irq), .soft_rst(soft_rst)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [3:0]  m_cfg;
  logic [25:0] m_tim;
  logic [5:0]  m_mask, m_stat;
  logic        m_key, m_ce, m_srst;
  logic [31:0] m_rdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [31:0] rv;
    bit sr;
    if (!rst_n) begin
      m_cfg = '0; m_tim = '0; m_mask = '0; m_stat = '0;
      m_key = 1'b0; m_ce = 1'b0; m_srst = 1'b0; m_rdata = '0;
    end else begin
      case (bus_addr)
        3'd1: rv = {31'd0, m_key};
        3'd2: rv = {28'd0, m_cfg};
        3'd3: rv = {6'd0, m_tim};
        3'd4: rv = {26'd0, m_mask};
        3'd5: rv = {26'd0, m_stat};
        3'd6: rv = {30'd0, ctrl_rdy, nand_rdy};
        3'd7: rv = {31'd0, m_ce};
        default: rv = '0;
      endcase
      m_rdata = bus_rd ? rv : '0;
      sr = bus_wr && bus_addr == 3'd0 && bus_wdata[7:0] == 8'hFF;
      m_srst = sr;
      if (sr) begin
        m_cfg = '0; m_tim = '0; m_mask = '0; m_stat = '0; m_key = 1'b0; m_ce = 1'b0;
      end else begin
        if (bus_rd && bus_addr == 3'd5) m_stat = '0;
        m_stat = m_stat | evt_pulse;
        if (bus_wr) begin
          case (bus_addr)
            3'd1: m_key = (bus_wdata[15:0] == 16'hA25E);
            3'd2: if (m_key) begin m_cfg = bus_wdata[3:0]; m_key = 1'b0; end
            3'd3: if (m_key) begin m_tim = bus_wdata[25:0]; m_key = 1'b0; end
            3'd4: m_mask = bus_wdata[5:0];
            3'd7: m_ce = bus_wdata[0];
            default: ;
          endcase
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 rdata", bus_rdata, m_rdata);
      chk("R3 if_cfg", {28'd0, if_cfg}, {28'd0, m_cfg});
      chk("R3 tim_cfg", {6'd0, tim_cfg}, {6'd0, m_tim});
      chk("R7 irq", {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
      chk("R9 ce_normal", {31'd0, ce_normal}, {31'd0, m_ce});
      chk("R10 soft_rst", {31'd0, soft_rst}, {31'd0, m_srst});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [5:0] e);
    @(negedge clk); evt_pulse = e;
    @(negedge clk); evt_pulse = '0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired before the sequence ended");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd_exp(3'd2, 32'h0, "R3 cfg reset");
    rd_exp(3'd3, 32'h0, "R3 tim reset");
    rd_exp(3'd1, 32'h0, "R1 key closed at reset");
    rd_exp(3'd0, 32'h0, "R4 command word reads zero");
    // locked writes dropped
    wr(3'd3, 32'h0012_3456);
    rd_exp(3'd3, 32'h0, "R2 locked timing write dropped");
    // single-use key
    wr(3'd1, 32'h0000_A25E);
    rd_exp(3'd1, 32'h1, "R1 key open");
    wr(3'd3, 32'hFFFF_FFFF);
    rd_exp(3'd3, 32'h03FF_FFFF, "R3 timing upper bits zero");
    rd_exp(3'd1, 32'h0, "R1 key closed after use");
    wr(3'd2, 32'h0000_000F);
    rd_exp(3'd2, 32'h0, "R2 second guarded write dropped");
    wr(3'd1, 32'hFFFF_A25E);
    wr(3'd2, 32'hFFFF_FFFF);
    rd_exp(3'd2, 32'hF, "R3 cfg written after unlock");
    wr(3'd1, 32'h0000_A25E);
    wr(3'd1, 32'h0000_1234);
    wr(3'd2, 32'h0);
    rd_exp(3'd2, 32'hF, "R1 wrong key closes lock");
    // sticky flags, masked
    pulse(6'b100001);
    chk("R7 irq masked off", {31'd0, irq}, 32'd0);
    rd_exp(3'd5, 32'h21, "R5 flags read");
    rd_exp(3'd5, 32'h0, "R5 flags cleared by read");
    // unmasked
    wr(3'd4, 32'h04);
    pulse(6'b000100);
    chk("R7 irq raised", {31'd0, irq}, 32'd1);
    rd_exp(3'd5, 32'h04, "R5 decode error flag");
    chk("R7 irq dropped after clear", {31'd0, irq}, 32'd0);
    // event during read
    @(negedge clk); bus_addr = 3'd5; bus_rd = 1'b1; evt_pulse = 6'b001000;
    @(negedge clk); bus_rd = 1'b0; evt_pulse = '0;
    chk("R6 read returns pre-event flags", bus_rdata, 32'h0);
    rd_exp(3'd5, 32'h08, "R6 event kept across read");
    // live status
    nand_rdy = 1'b1; ctrl_rdy = 1'b0;
    rd_exp(3'd6, 32'h1, "R8 flash ready live");
    nand_rdy = 1'b0; ctrl_rdy = 1'b1;
    rd_exp(3'd6, 32'h2, "R8 controller ready live");
    // read-only words
    wr(3'd5, 32'h3F);
    rd_exp(3'd5, 32'h0, "R11 status write ignored");
    wr(3'd6, 32'h0);
    rd_exp(3'd6, 32'h2, "R11 live write ignored");
    // chip enable
    wr(3'd7, 32'h1);
    chk("R9 ce_normal set", {31'd0, ce_normal}, 32'd1);
    rd_exp(3'd7, 32'h1, "R9 ce readback");
    // commands
    wr(3'd1, 32'hA25E);
    wr(3'd3, 32'h0155_5555);
    wr(3'd4, 32'h3F);
    wr(3'd0, 32'h12);
    rd_exp(3'd2, 32'hF, "R10 other command ignored");
    wr(3'd0, 32'hFF);
    chk("R10 soft reset pulse", {31'd0, soft_rst}, 32'd1);
    @(negedge clk);
    chk("R10 soft reset single cycle", {31'd0, soft_rst}, 32'd0);
    rd_exp(3'd2, 32'h0, "R10 cfg cleared");
    rd_exp(3'd3, 32'h0, "R10 timing cleared");
    rd_exp(3'd4, 32'h0, "R10 mask cleared");
    rd_exp(3'd7, 32'h0, "R10 ce cleared");
    wr(3'd1, 32'hA25E);
    wr(3'd0, 32'hFF);
    wr(3'd3, 32'h5);
    rd_exp(3'd3, 32'h0, "R10 key closed by soft reset");
    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule